// File: doc/BRIEF.md
# Serial Console Line Assembler

This block sits behind a serial transmit port and turns the stream of characters written to it into whole text lines for a downstream consumer. Each accepted character passes through a line-ending filter: a carriage return (0x0D) is stored as a line feed (0x0A), and a line feed that arrives after a carriage return is swallowed. The filtered characters collect in a line buffer. A line is closed as soon as a line feed is stored, or when the buffer holds one character fewer than its depth.

A closed line is offered to the consumer through a valid flag and a length. The consumer reads the characters through a random-access read port, where the address equal to the length returns a zero terminator. It releases the buffer with an acknowledge. The write side accepts single-character writes and full 32-bit word writes. A word write is fed to the filter one character per cycle, starting with the low byte. While a line waits for its acknowledge, the write side stalls through its ready output, so no character is lost.

Top module: `con_line_asm`

## Requirements
- R1: Reset (synchronous, active low) leaves no line pending, `wr_ready` high, an empty buffer and the carriage-return memory cleared, so a line feed written first after reset is stored as a one-character line.
- R2: A written 0x0D is stored as 0x0A, and it sets the carriage-return memory.
- R3: A 0x0A written while the carriage-return memory is set is discarded, and the memory stays set, so further 0x0A bytes are also discarded.
- R4: Any stored byte other than one coming from 0x0D clears the carriage-return memory, and every byte other than 0x0D and 0x0A is stored unchanged.
- R5: Storing 0x0A closes the line: `line_valid` rises with `line_len` equal to the number of stored bytes, including the 0x0A.
- R6: When the stored count reaches DEPTH-1 without a 0x0A, the line closes with `line_len` = DEPTH-1. The next byte starts a new line.
- R7: A write with `wr_wide` = 1 is processed as four byte writes, in the order `wr_data[7:0]`, `[15:8]`, `[23:16]`, `[31:24]`. A write with `wr_wide` = 0 uses `wr_data[7:0]` only.
- R8: While a line is valid, `rd_data` returns the stored byte at index `rd_addr` when `rd_addr` < `line_len`, and 0x00 at index `line_len`.
- R9: `line_valid` and `line_len` stay unchanged until `line_ack` is sampled high. The next line then starts from an empty buffer.
- R10: While a line is valid, `wr_ready` is low and no byte is taken in, including the remaining bytes of a word write. No byte is dropped by the stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_valid | input | 1 | Write request to the transmit port |
| wr_wide | input | 1 | 1: 32-bit word write, 0: single byte write |
| wr_data | input | WORD_W | Write data; a byte write uses bits 7:0 |
| wr_ready | output | 1 | Write accepted on a clock edge where it is high together with wr_valid |
| line_valid | output | 1 | A complete line is held for the consumer |
| line_len | output | $clog2(DEPTH) | Number of characters in the held line |
| line_ack | input | 1 | Consumer releases the held line |
| rd_addr | input | $clog2(DEPTH) | Character index to read |
| rd_data | output | 8 | Character at rd_addr, or zero at and past line_len |

## Verification
The bench feeds the filter several kinds of input. Plain text ending in a line feed separates the normal close from the fill close. Carriage-return runs, such as CR alone, CR-LF, CR-LF-LF and CR followed by a character and then LF, show whether the carriage-return memory is set, kept and cleared at the right byte. Word writes built from every four-symbol combination of a letter, CR and LF show the lane order and how the stall behaves when a line closes in the middle of a word. A sweep of all 256 byte values written as single bytes shows that only the two line-ending codes are altered. The sweep also pushes many lines through the fill limit. Resets placed after a partial line and after a lone carriage return show that both the count and the memory are cleared.

// File: rtl/cla_pkg.sv
// Shared character type and the control codes used by the line assembler.
// Assumes 8-bit characters.
package cla_pkg;
    typedef logic [7:0] char_t;

    localparam char_t CHAR_CR  = 8'h0D;
    localparam char_t CHAR_LF  = 8'h0A;
    localparam char_t CHAR_NUL = 8'h00;
endpackage

// File: rtl/cla_word_split.sv
// Takes one write (byte or full word) into a holding register and hands
// its bytes downstream one per cycle, lowest lane first.
// Assumes WORD_W is a multiple of 8. A new write is taken only when the
// previous one is fully consumed and the downstream can take a byte.
module cla_word_split
    import cla_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic              wr_wide,
    input  logic [WORD_W-1:0] wr_data,
    output logic              wr_ready,
    output logic              out_valid,
    output char_t             out_char,
    input  logic              out_take
);
    localparam int LANES = WORD_W / 8;
    localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int REM_W = $clog2(LANES + 1);

    logic [WORD_W-1:0] hold_q;
    logic [REM_W-1:0]  left_q;
    logic [IDX_W-1:0]  lane_q;
    char_t             lane_char [LANES];

    // Slice the held word into byte lanes.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_char[g] = hold_q[g*8 +: 8];
    end

    // Present the current lane and the write-side handshake.
    always_comb begin
        out_valid = (left_q != '0);
        out_char  = lane_char[lane_q];
        wr_ready  = (left_q == '0) && out_take;
    end

    // Load a new write or step to the next lane once a byte is consumed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            left_q <= '0;
            lane_q <= '0;
        end else if (wr_valid && wr_ready) begin
            hold_q <= wr_data;
            left_q <= wr_wide ? REM_W'(LANES) : REM_W'(1);
            lane_q <= '0;
        end else if (out_valid && out_take) begin
            left_q <= left_q - 1'b1;
            lane_q <= lane_q + 1'b1;
        end
    end
endmodule

// File: rtl/cla_eol_filter.sv
// Line-ending filter: turns CR into LF, drops an LF that follows a CR
// (and keeps dropping LFs until another byte is stored), and remembers
// whether the last byte was a CR.
// Assumes a byte is consumed on any cycle where in_valid and in_take are high.
module cla_eol_filter
    import cla_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  in_valid,
    input  char_t in_char,
    input  logic  in_take,
    output logic  st_en,
    output char_t st_char
);
    logic cr_seen_q;
    logic fire;
    logic is_cr;
    logic drop;

    // Decide whether the consumed byte is stored, and in which form.
    always_comb begin
        fire    = in_valid && in_take;
        is_cr   = (in_char == CHAR_CR);
        drop    = (in_char == CHAR_LF) && cr_seen_q;
        st_en   = fire && !drop;
        st_char = is_cr ? CHAR_LF : in_char;
    end

    // Track whether the most recent stored byte came from a CR.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cr_seen_q <= 1'b0;
        end else if (fire) begin
            if (is_cr) begin
                cr_seen_q <= 1'b1;
            end else if (!drop) begin
                cr_seen_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/cla_line_buf.sv
// Line buffer: stores filtered characters, closes a line on LF or when
// DEPTH-1 characters are held, and keeps it for the consumer until it is
// acknowledged. The read port returns zero at and beyond the line length.
// Assumes st_en is only raised while accept is high.
module cla_line_buf
    import cla_pkg::*;
#(
    parameter int DEPTH = 1024
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     st_en,
    input  char_t                    st_char,
    output logic                     accept,
    output logic                     line_valid,
    output logic [$clog2(DEPTH)-1:0] line_len,
    input  logic                     line_ack,
    input  logic [$clog2(DEPTH)-1:0] rd_addr,
    output char_t                    rd_data
);
    localparam int ADDR_W = $clog2(DEPTH);
    localparam logic [ADDR_W-1:0] FULL_MARK = ADDR_W'(DEPTH - 1);

    char_t             store_mem [DEPTH];
    logic [ADDR_W-1:0] fill_q;
    logic [ADDR_W-1:0] fill_inc;
    logic [ADDR_W-1:0] len_q;
    logic              pend_q;
    logic              close_now;

    // Next fill level and the line-close condition.
    always_comb begin
        fill_inc  = fill_q + 1'b1;
        close_now = st_en && ((st_char == CHAR_LF) || (fill_inc == FULL_MARK));
    end

    // Write the stored character at the current fill position.
    always_ff @(posedge clk) begin
        if (st_en) begin
            store_mem[fill_q] <= st_char;
        end
    end

    // Fill counter, pending flag and captured line length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q <= '0;
            len_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            if (pend_q && line_ack) begin
                pend_q <= 1'b0;
            end
            if (st_en) begin
                if (close_now) begin
                    fill_q <= '0;
                    len_q  <= fill_inc;
                    pend_q <= 1'b1;
                end else begin
                    fill_q <= fill_inc;
                end
            end
        end
    end

    // Outputs towards the consumer and the upstream stall.
    always_comb begin
        accept     = !pend_q;
        line_valid = pend_q;
        line_len   = len_q;
        rd_data    = (rd_addr < len_q) ? store_mem[rd_addr] : CHAR_NUL;
    end
endmodule

// File: rtl/con_line_asm.sv
// Serial console line assembler top: write splitter, line-ending filter
// and line buffer in series. One character moves per cycle. A held line
// stalls the write side until the consumer acknowledges it.
// Assumes DEPTH is a power of two of at least 4 and WORD_W a multiple of 8.
module con_line_asm
    import cla_pkg::*;
#(
    parameter int DEPTH  = 1024,
    parameter int WORD_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_valid,
    input  logic                     wr_wide,
    input  logic [WORD_W-1:0]        wr_data,
    output logic                     wr_ready,
    output logic                     line_valid,
    output logic [$clog2(DEPTH)-1:0] line_len,
    input  logic                     line_ack,
    input  logic [$clog2(DEPTH)-1:0] rd_addr,
    output logic [7:0]               rd_data
);
    logic  byte_valid;
    char_t byte_char;
    logic  take;
    logic  st_en;
    char_t st_char;

    cla_word_split #(.WORD_W(WORD_W)) u_split (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .wr_wide   (wr_wide),
        .wr_data   (wr_data),
        .wr_ready  (wr_ready),
        .out_valid (byte_valid),
        .out_char  (byte_char),
        .out_take  (take)
    );

    cla_eol_filter u_filt (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (byte_valid),
        .in_char  (byte_char),
        .in_take  (take),
        .st_en    (st_en),
        .st_char  (st_char)
    );

    cla_line_buf #(.DEPTH(DEPTH)) u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .st_en      (st_en),
        .st_char    (st_char),
        .accept     (take),
        .line_valid (line_valid),
        .line_len   (line_len),
        .line_ack   (line_ack),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data)
    );
endmodule

// File: rtl/cla_line_asm_chk.sv
// Protocol checker for the line assembler, bound into every instance.
module cla_line_asm_chk
    import cla_pkg::*;
#(
    parameter int DEPTH = 1024
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     wr_ready,
    input logic                     line_valid,
    input logic [$clog2(DEPTH)-1:0] line_len,
    input logic                     line_ack,
    input logic                     st_en,
    input char_t                    st_char
);
    // R1
    reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !line_valid && wr_ready);

    // R2
    no_cr_stored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_en |-> st_char != CHAR_CR);

    // R5
    close_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_valid) |-> $past(st_en));

    // R6
    len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid |-> (line_len != '0) && (int'(line_len) <= DEPTH - 1));

    // R9
    hold_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid && !line_ack |=> line_valid && $stable(line_len));

    // R10
    stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid |-> !wr_ready && !st_en);
endmodule

bind con_line_asm cla_line_asm_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_ready   (wr_ready),
    .line_valid (line_valid),
    .line_len   (line_len),
    .line_ack   (line_ack),
    .st_en      (st_en),
    .st_char    (st_char)
);

// File: tb/con_line_asm_tb.sv
`timescale 1ns/10ps
module con_line_asm_tb;
    localparam int DEPTH = 8;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wr_valid;
    logic          wr_wide;
    logic [31:0]   wr_data;
    logic          wr_ready;
    logic          line_valid;
    logic [AW-1:0] line_len;
    logic          line_ack;
    logic [AW-1:0] rd_addr;
    logic [7:0]    rd_data;

    always #2.5 clk = ~clk;

    con_line_asm #(.DEPTH(DEPTH), .WORD_W(32)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_wide(wr_wide),
        .wr_data(wr_data), .wr_ready(wr_ready), .line_valid(line_valid),
        .line_len(line_len), .line_ack(line_ack), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    int    n_lines = 0;
    string cur_req = "R1";

    logic [7:0] exp_data [$];
    int         exp_len  [$];
    logic [7:0] mbuf     [$];
    bit         mcr;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Reference model of the filter and line closing, from the requirements.
    function automatic void model_byte(input logic [7:0] b);
        bit st;
        st = 1'b0;
        if (b == 8'h0D) begin
            mcr = 1'b1;
            mbuf.push_back(8'h0A);
            st = 1'b1;
        end else if (!(mcr && b == 8'h0A)) begin
            mcr = 1'b0;
            mbuf.push_back(b);
            st = 1'b1;
        end
        if (st && (mbuf[mbuf.size()-1] == 8'h0A || mbuf.size() == DEPTH - 1)) begin
            exp_len.push_back(mbuf.size());
            foreach (mbuf[i]) exp_data.push_back(mbuf[i]);
            mbuf.delete();
        end
    endfunction

    task automatic put_byte(input logic [7:0] b);
        @(negedge clk);
        while (!wr_ready) @(negedge clk);
        wr_valid = 1'b1;
        wr_wide  = 1'b0;
        wr_data  = {24'h0, b};
        model_byte(b);
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic put_word(input logic [31:0] w);
        @(negedge clk);
        while (!wr_ready) @(negedge clk);
        wr_valid = 1'b1;
        wr_wide  = 1'b1;
        wr_data  = w;
        for (int k = 0; k < 4; k++) model_byte(w[k*8 +: 8]);
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic put_str(input string s);
        for (int i = 0; i < s.len(); i++) put_byte(s[i]);
    endtask

    task automatic drain();
        @(negedge clk);
        while (exp_len.size() != 0 || line_valid || !wr_ready) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        mcr = 1'b0;
        mbuf.delete();
    endtask

    // Consumer: read every held line, compare, hold a while, acknowledge.
    initial begin
        line_ack = 1'b0;
        rd_addr  = '0;
        forever begin
            @(negedge clk);
            if (rst_n && line_valid) begin
                int len;
                int exl;
                int bad_idx;
                int bad_val;
                bit ok;
                len = int'(line_len);
                ok  = 1'b1;
                bad_idx = -1;
                bad_val = 0;
                if (exp_len.size() == 0) begin
                    check(1'b0, cur_req, "unexpected line, length", len, 0);
                end else begin
                    exl = exp_len.pop_front();
                    check(len == exl, cur_req, "line length", len, exl);
                    for (int i = 0; i < exl; i++) begin
                        logic [7:0] e;
                        e = exp_data.pop_front();
                        rd_addr = AW'(i);
                        #0.1;
                        if (ok && rd_data != e) begin
                            ok = 1'b0;
                            bad_idx = i;
                            bad_val = int'(e);
                            check(1'b0, cur_req, $sformatf("line byte %0d", i), int'(rd_data), int'(e));
                        end
                    end
                    if (ok) check(1'b1, cur_req, "line bytes", 0, 0);
                end
                // R8 terminator at index line_len
                rd_addr = AW'(len);
                #0.1;
                check(rd_data == 8'h00, "R8", "terminator", int'(rd_data), 0);
                // R10 write side stalled while held
                check(!wr_ready, "R10", "wr_ready while line held", int'(wr_ready), 0);
                // R9 line held unchanged until ack
                repeat (n_lines % 3) begin
                    @(negedge clk);
                    check(line_valid && int'(line_len) == len, "R9", "held line length",
                          int'(line_len), len);
                end
                n_lines++;
                line_ack = 1'b1;
                @(negedge clk);
                line_ack = 1'b0;
                rd_addr  = '0;
            end
        end
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n    = 1'b0;
        wr_valid = 1'b0;
        wr_wide  = 1'b0;
        wr_data  = '0;
        mcr      = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!line_valid, "R1", "line_valid in reset", int'(line_valid), 0);
        check(wr_ready, "R1", "wr_ready in reset", int'(wr_ready), 1);
        rst_n = 1'b1;

        cur_req = "R5";
        put_str("hi\n");
        put_byte(8'h0A);
        drain();

        cur_req = "R2";
        put_str("ab\r");
        put_byte(8'h0D);
        drain();

        cur_req = "R3";
        put_str("\r\n\nx\n");
        drain();

        cur_req = "R4";
        put_str("\rz\n");
        put_str("\rq\r\n");
        drain();

        cur_req = "R6";
        put_str("abcdefg");
        put_str("0123456789\n");
        drain();

        cur_req = "R7";
        put_word(32'h0A636261);
        put_word(32'h6B0A6A69);
        put_byte(8'h0A);
        drain();
        for (int a = 0; a < 81; a++) begin
            logic [31:0] w;
            int r;
            r = a;
            for (int k = 0; k < 4; k++) begin
                case (r % 3)
                    0:       w[k*8 +: 8] = 8'h61 + 8'(k);
                    1:       w[k*8 +: 8] = 8'h0D;
                    default: w[k*8 +: 8] = 8'h0A;
                endcase
                r = r / 3;
            end
            put_word(w);
        end
        drain();

        cur_req = "R4";
        for (int v = 0; v < 256; v++) put_byte(8'(v));
        put_byte(8'h0A);
        drain();

        cur_req = "R1";
        put_str("ab");
        drain();
        pulse_reset();
        put_str("c\n");
        drain();
        put_byte(8'h0D);
        drain();
        pulse_reset();
        put_byte(8'h0A);
        drain();

        check(exp_len.size() == 0, "R5", "lines still expected", exp_len.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule